// File: doc/BRIEF.md
# Clock-Crossing Bus-to-Register Bridge

This block sits between a memory-mapped CPU bus clocked by `cpu_clk` and a plain register port clocked by an unrelated `usr_clk`. Every bus access is classified by its upper address bits. Two of the codes select local RAM windows, and those accesses are steered straight to the RAM ports on the bus clock with no wait state. Every other code is carried across the clock boundary. There it becomes either a single-cycle register write, with a word address, data and byte lanes, or a single-cycle read request that is completed by a read-valid strobe.

Each forwarded access holds the bus in a wait state until its completion has been synchronised back. Only one forwarded transaction is in flight at a time. Request and completion each cross as a toggle through a two-flop synchroniser. The payload (address, data, lanes, direction, read data) is held stable in a register while its toggle travels.

Top module: `xbr_bridge`

## Requirements
- R1: The select field is `bus_addr[13:9]`. Code 5'b00001 routes to RAM window 0 and code 5'b00010 to RAM window 1. Every other code, including 0, 3 and 31, is forwarded to the register port.
- R2: A write to a RAM window raises only that window's bit of `win_we` (bit 0 for window 0) in the same cycle. It presents `bus_addr[8:0]`, the write data and the byte lanes unchanged, inserts no wait state and causes no register strobe.
- R3: A read from a RAM window is accepted without a wait state. `bus_rvalid` rises exactly 2 cycles after the accepting edge, carrying that window's read data (`win_rdata[31:0]` for window 0, `[63:32]` for window 1).
- R4: A forwarded write produces exactly one `reg_wr` pulse, one user-clock cycle long. It carries `reg_addr = bus_addr[13:2]` (the word address) and the write data unchanged.
- R5: Byte lanes are carried unchanged. `reg_be[i]` qualifies `reg_wdata[8i+7:8i]`, so a write with lanes 4'b0101 changes only bytes 0 and 2 of the target register.
- R6: A forwarded read produces exactly one single-cycle `reg_rd` pulse with the word address. The value on `reg_rdata` in the cycle `reg_rvalid` is high is returned on `bus_rdata`, with `bus_rvalid` high in the cycle the bus access is released.
- R7: `bus_wait` is high from the first cycle of a forwarded access until its completion is seen on the CPU clock. At least 3 cycles are waited, and the request must stay asserted while waiting.
- R8: At most one forwarded transaction is outstanding. `reg_wr` and `reg_rd` never rise together, and back-to-back accesses each yield exactly one strobe.
- R9: After reset in both domains, `bus_wait` and `bus_rvalid` are low while idle, and no `reg_wr` or `reg_rd` strobe appears.
- R10: Correct operation does not depend on the ratio of the two clocks. The user clock may be faster or slower than the bus clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Bus-side clock |
| cpu_rst | input | 1 | Synchronous active-high reset, bus side |
| bus_addr | input | 14 | Byte address of the bus access |
| bus_write | input | 1 | Bus write request |
| bus_read | input | 1 | Bus read request |
| bus_wdata | input | 32 | Bus write data |
| bus_be | input | 4 | Bus byte lanes |
| bus_wait | output | 1 | Wait state; the access is accepted on an edge where it is low |
| bus_rdata | output | 32 | Read data returned to the bus |
| bus_rvalid | output | 1 | Read data valid strobe |
| win_addr | output | 9 | Address within a RAM window |
| win_wdata | output | 32 | RAM window write data |
| win_be | output | 4 | RAM window byte lanes |
| win_we | output | 2 | Per-window write enable |
| win_re | output | 2 | Per-window read enable |
| win_rdata | input | 64 | Read data of both windows, window 0 in the low word |
| usr_clk | input | 1 | Register-side clock |
| usr_rst | input | 1 | Synchronous active-high reset, register side |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_rd | output | 1 | Single-cycle register read request |
| reg_addr | output | 12 | Register word address |
| reg_wdata | output | 32 | Register write data |
| reg_be | output | 4 | Register byte lanes |
| reg_rvalid | input | 1 | Register read data valid |
| reg_rdata | input | 32 | Register read data |

## Verification
The assertions rely on three things at the block's inputs. First, the bus master keeps its request asserted and unchanged for as long as `bus_wait` is high, and never raises read and write together. Second, `reg_rvalid` only answers a read request that is still waiting. Third, both domains are reset before traffic starts. The bench master drives one access at a time and holds it until release. The register model answers each read exactly once, two user cycles after the request. The RAM model returns data with the fixed two-cycle latency the window read path expects.

// File: rtl/xbr_pkg.sv
package xbr_pkg;

    typedef enum logic {
        CPU_IDLE,
        CPU_BUSY
    } cpu_state_e;

    typedef enum logic {
        USR_IDLE,
        USR_RDWAIT
    } usr_state_e;

endpackage

// File: rtl/xbr_sync.sv
module xbr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    // STAGES must be 2 or more
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xbr_route.sv
module xbr_route #(
    parameter int ADDR_W     = 14,
    parameter int DATA_W     = 32,
    parameter int SEL_LSB    = 9,
    parameter int NWIN       = 2,
    parameter int WIN_BASE   = 1,
    parameter int RAM_RD_LAT = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_write,
    input  logic                   bus_read,
    input  logic [DATA_W-1:0]      bus_wdata,
    input  logic [DATA_W/8-1:0]    bus_be,
    input  logic [NWIN*DATA_W-1:0] win_rdata,
    input  logic                   fwd_rvalid,
    input  logic [DATA_W-1:0]      fwd_rdata,
    output logic [SEL_LSB-1:0]     win_addr,
    output logic [DATA_W-1:0]      win_wdata,
    output logic [DATA_W/8-1:0]    win_be,
    output logic [NWIN-1:0]        win_we,
    output logic [NWIN-1:0]        win_re,
    output logic                   fwd_req,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   bus_rvalid
);
    localparam int SEL_W = ADDR_W - SEL_LSB;
    localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } ret_t;

    logic [NWIN-1:0]  hit;
    logic [IDX_W-1:0] hit_idx;
    ret_t [RAM_RD_LAT-1:0] pipe_d, pipe_q;
    ret_t ret_out;

    // one comparator per window, code = WIN_BASE + window index
    for (genvar i = 0; i < NWIN; i++) begin : g_hit
        assign hit[i] = (bus_addr[ADDR_W-1:SEL_LSB] == SEL_W'(WIN_BASE + i));
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (hit[i]) hit_idx = IDX_W'(i);
        end
    end

    assign win_addr  = bus_addr[SEL_LSB-1:0];
    assign win_wdata = bus_wdata;
    assign win_be    = bus_be;
    assign win_we    = hit & {NWIN{bus_write}};
    assign win_re    = hit & {NWIN{bus_read}};
    assign fwd_req   = (bus_write | bus_read) & ~(|hit);

    // fixed-latency return path for window reads
    always_comb begin
        pipe_d[0] = '{vld: bus_read & (|hit), idx: hit_idx};
        for (int k = 1; k < RAM_RD_LAT; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign ret_out    = pipe_q[RAM_RD_LAT-1];
    assign bus_rvalid = fwd_rvalid | ret_out.vld;
    assign bus_rdata  = fwd_rvalid ? fwd_rdata
                                   : win_rdata[DATA_W*int'(ret_out.idx) +: DATA_W];

    // a forwarded completion never collides with a window return
    assert_single_return_R3: assert property (@(posedge clk) disable iff (rst)
        !(fwd_rvalid && ret_out.vld));

    // a window hit never starts a forwarded request
    assert_window_local_R2: assert property (@(posedge clk) disable iff (rst)
        (|win_we || |win_re) |-> !fwd_req);
endmodule

// File: rtl/xbr_cpu_side.sv
module xbr_cpu_side
    import xbr_pkg::*;
#(
    parameter int WADDR_W     = 12,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fwd_req,
    input  logic                bus_write,
    input  logic [WADDR_W-1:0]  bus_waddr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic                ack_tgl,
    input  logic [DATA_W-1:0]   usr_rdata,
    output logic                bus_wait,
    output logic                fwd_rvalid,
    output logic [DATA_W-1:0]   fwd_rdata,
    output logic                req_tgl,
    output logic                req_write,
    output logic [WADDR_W-1:0]  req_addr,
    output logic [DATA_W-1:0]   req_wdata,
    output logic [DATA_W/8-1:0] req_be
);
    localparam int BE_W = DATA_W / 8;

    typedef struct packed {
        cpu_state_e          state;
        logic                req_tgl;
        logic                ack_seen;
        logic                is_write;
        logic [WADDR_W-1:0]  addr;
        logic [DATA_W-1:0]   wdata;
        logic [BE_W-1:0]     be;
    } cpu_regs_t;

    cpu_regs_t d_d, d_q;
    logic ack_sync, ack_edge, done;

    xbr_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_tgl),
        .q   (ack_sync)
    );

    assign ack_edge = (ack_sync != d_q.ack_seen);
    assign done     = (d_q.state == CPU_BUSY) && ack_edge;

    always_comb begin
        d_d = d_q;
        case (d_q.state)
            CPU_IDLE: begin
                if (fwd_req) begin
                    d_d.state    = CPU_BUSY;
                    d_d.req_tgl  = ~d_q.req_tgl;
                    d_d.is_write = bus_write;
                    d_d.addr     = bus_waddr;
                    d_d.wdata    = bus_wdata;
                    d_d.be       = bus_be;
                end
            end
            default: begin
                if (ack_edge) begin
                    d_d.ack_seen = ack_sync;
                    d_d.state    = CPU_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) d_q <= '0;
        else     d_q <= d_d;
    end

    assign bus_wait   = fwd_req && !done;
    assign fwd_rvalid = done && !d_q.is_write;
    assign fwd_rdata  = usr_rdata;
    assign req_tgl    = d_q.req_tgl;
    assign req_write  = d_q.is_write;
    assign req_addr   = d_q.addr;
    assign req_wdata  = d_q.wdata;
    assign req_be     = d_q.be;

    // completion only arrives for an outstanding transaction
    assert_ack_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
        ack_edge |-> (d_q.state == CPU_BUSY));

    // the master keeps its request up while waited
    assert_hold_request_R7: assert property (@(posedge clk) disable iff (rst)
        bus_wait |=> fwd_req);
endmodule

// File: rtl/xbr_usr_side.sv
module xbr_usr_side
    import xbr_pkg::*;
#(
    parameter int WADDR_W     = 12,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_tgl,
    input  logic                req_write,
    input  logic [WADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    input  logic                reg_rvalid,
    input  logic [DATA_W-1:0]   reg_rdata,
    output logic                reg_wr,
    output logic                reg_rd,
    output logic [WADDR_W-1:0]  reg_addr,
    output logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W/8-1:0] reg_be,
    output logic                ack_tgl,
    output logic [DATA_W-1:0]   rdata_hold
);
    localparam int BE_W = DATA_W / 8;

    typedef struct packed {
        usr_state_e          state;
        logic                req_seen;
        logic                ack_tgl;
        logic                wr;
        logic                rd;
        logic [WADDR_W-1:0]  addr;
        logic [DATA_W-1:0]   wdata;
        logic [BE_W-1:0]     be;
        logic [DATA_W-1:0]   rdata;
    } usr_regs_t;

    usr_regs_t u_d, u_q;
    logic req_sync, req_edge;

    xbr_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_tgl),
        .q   (req_sync)
    );

    assign req_edge = (req_sync != u_q.req_seen);

    always_comb begin
        u_d    = u_q;
        u_d.wr = 1'b0;
        u_d.rd = 1'b0;
        case (u_q.state)
            USR_IDLE: begin
                if (req_edge) begin
                    u_d.req_seen = req_sync;
                    u_d.addr     = req_addr;
                    u_d.wdata    = req_wdata;
                    u_d.be       = req_be;
                    if (req_write) begin
                        u_d.wr      = 1'b1;
                        u_d.ack_tgl = ~u_q.ack_tgl;
                    end else begin
                        u_d.rd    = 1'b1;
                        u_d.state = USR_RDWAIT;
                    end
                end
            end
            default: begin
                if (reg_rvalid) begin
                    u_d.rdata   = reg_rdata;
                    u_d.ack_tgl = ~u_q.ack_tgl;
                    u_d.state   = USR_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) u_q <= '0;
        else     u_q <= u_d;
    end

    assign reg_wr     = u_q.wr;
    assign reg_rd     = u_q.rd;
    assign reg_addr   = u_q.addr;
    assign reg_wdata  = u_q.wdata;
    assign reg_be     = u_q.be;
    assign ack_tgl    = u_q.ack_tgl;
    assign rdata_hold = u_q.rdata;

    assert_wr_single_R4: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    assert_rd_single_R6: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> !reg_rd);

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    // a new request never arrives while a read is still open
    assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (rst)
        req_edge |-> (u_q.state == USR_IDLE));

    // read data only answers an open read
    assert_rvalid_expected_R6: assert property (@(posedge clk) disable iff (rst)
        reg_rvalid |-> (u_q.state == USR_RDWAIT));
endmodule

// File: rtl/xbr_bridge.sv
module xbr_bridge #(
    parameter int ADDR_W      = 14,
    parameter int DATA_W      = 32,
    parameter int SEL_LSB     = 9,
    parameter int NWIN        = 2,
    parameter int WIN_BASE    = 1,
    parameter int RAM_RD_LAT  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   cpu_clk,
    input  logic                   cpu_rst,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_write,
    input  logic                   bus_read,
    input  logic [DATA_W-1:0]      bus_wdata,
    input  logic [DATA_W/8-1:0]    bus_be,
    output logic                   bus_wait,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   bus_rvalid,
    output logic [SEL_LSB-1:0]     win_addr,
    output logic [DATA_W-1:0]      win_wdata,
    output logic [DATA_W/8-1:0]    win_be,
    output logic [NWIN-1:0]        win_we,
    output logic [NWIN-1:0]        win_re,
    input  logic [NWIN*DATA_W-1:0] win_rdata,
    input  logic                   usr_clk,
    input  logic                   usr_rst,
    output logic                   reg_wr,
    output logic                   reg_rd,
    output logic [ADDR_W-3:0]      reg_addr,
    output logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W/8-1:0]    reg_be,
    input  logic                   reg_rvalid,
    input  logic [DATA_W-1:0]      reg_rdata
);
    localparam int WADDR_W = ADDR_W - 2;
    localparam int BE_W    = DATA_W / 8;

    logic               fwd_req, fwd_rvalid;
    logic [DATA_W-1:0]  fwd_rdata, rdata_hold;
    logic               req_tgl, req_write, ack_tgl;
    logic [WADDR_W-1:0] req_addr;
    logic [DATA_W-1:0]  req_wdata;
    logic [BE_W-1:0]    req_be;

    xbr_route #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_LSB(SEL_LSB),
        .NWIN(NWIN), .WIN_BASE(WIN_BASE), .RAM_RD_LAT(RAM_RD_LAT)
    ) u_route (
        .clk        (cpu_clk),
        .rst        (cpu_rst),
        .bus_addr   (bus_addr),
        .bus_write  (bus_write),
        .bus_read   (bus_read),
        .bus_wdata  (bus_wdata),
        .bus_be     (bus_be),
        .win_rdata  (win_rdata),
        .fwd_rvalid (fwd_rvalid),
        .fwd_rdata  (fwd_rdata),
        .win_addr   (win_addr),
        .win_wdata  (win_wdata),
        .win_be     (win_be),
        .win_we     (win_we),
        .win_re     (win_re),
        .fwd_req    (fwd_req),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    xbr_cpu_side #(
        .WADDR_W(WADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_cpu (
        .clk        (cpu_clk),
        .rst        (cpu_rst),
        .fwd_req    (fwd_req),
        .bus_write  (bus_write),
        .bus_waddr  (bus_addr[ADDR_W-1:2]),
        .bus_wdata  (bus_wdata),
        .bus_be     (bus_be),
        .ack_tgl    (ack_tgl),
        .usr_rdata  (rdata_hold),
        .bus_wait   (bus_wait),
        .fwd_rvalid (fwd_rvalid),
        .fwd_rdata  (fwd_rdata),
        .req_tgl    (req_tgl),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_be     (req_be)
    );

    xbr_usr_side #(
        .WADDR_W(WADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_usr (
        .clk        (usr_clk),
        .rst        (usr_rst),
        .req_tgl    (req_tgl),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_be     (req_be),
        .reg_rvalid (reg_rvalid),
        .reg_rdata  (reg_rdata),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_be     (reg_be),
        .ack_tgl    (ack_tgl),
        .rdata_hold (rdata_hold)
    );
endmodule

// File: tb/xbr_bridge_bench.sv
`timescale 1ns/1ps
module xbr_bridge_bench;
    logic        cpu_clk = 1'b0;
    logic        usr_clk = 1'b0;
    logic        cpu_rst = 1'b1;
    logic        usr_rst = 1'b1;
    logic [13:0] bus_addr = '0;
    logic        bus_write = 1'b0;
    logic        bus_read = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic        bus_wait, bus_rvalid;
    logic [31:0] bus_rdata;
    logic [8:0]  win_addr;
    logic [31:0] win_wdata;
    logic [3:0]  win_be;
    logic [1:0]  win_we, win_re;
    logic [63:0] win_rdata;
    logic        reg_wr, reg_rd;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [3:0]  reg_be;
    logic        reg_rvalid = 1'b0;
    logic [31:0] reg_rdata = '0;

    realtime usr_half = 5.0;
    int errors = 0;
    int checks = 0;

    always #2 cpu_clk = ~cpu_clk;
    always #(usr_half) usr_clk = ~usr_clk;

    xbr_bridge u_xbr_bridge (
        .cpu_clk, .cpu_rst, .bus_addr, .bus_write, .bus_read, .bus_wdata, .bus_be,
        .bus_wait, .bus_rdata, .bus_rvalid, .win_addr, .win_wdata, .win_be,
        .win_we, .win_re, .win_rdata, .usr_clk, .usr_rst, .reg_wr, .reg_rd,
        .reg_addr, .reg_wdata, .reg_be, .reg_rvalid, .reg_rdata
    );

    // RAM window model, two-cycle read latency
    logic [31:0] ram [2][128];
    logic [31:0] r1 [2];
    logic [31:0] r2 [2];
    always @(posedge cpu_clk) begin
        for (int i = 0; i < 2; i++) begin
            if (win_we[i])
                for (int b = 0; b < 4; b++)
                    if (win_be[b]) ram[i][win_addr[8:2]][8*b +: 8] <= win_wdata[8*b +: 8];
            r1[i] <= ram[i][win_addr[8:2]];
            r2[i] <= r1[i];
        end
    end
    assign win_rdata = {r2[1], r2[0]};

    // register file model on the user clock
    logic [31:0] regs [64];
    logic        rv1 = 1'b0;
    logic [31:0] rd1 = '0;
    int          wr_cnt = 0, rd_cnt = 0, both_cnt = 0;
    logic [11:0] last_wr_addr = '0, last_rd_addr = '0;
    logic [31:0] last_wdata = '0;
    logic [3:0]  last_be = '0;
    initial for (int i = 0; i < 64; i++) regs[i] = '0;

    always @(posedge usr_clk) begin
        if (usr_rst) begin
            rv1 <= 1'b0;
            reg_rvalid <= 1'b0;
        end else begin
            rv1 <= reg_rd;
            rd1 <= regs[reg_addr[5:0]];
            reg_rvalid <= rv1;
            reg_rdata <= rd1;
            if (reg_wr && reg_rd) both_cnt++;
            if (reg_wr) begin
                wr_cnt++;
                last_wr_addr = reg_addr;
                last_wdata = reg_wdata;
                last_be = reg_be;
                for (int b = 0; b < 4; b++)
                    if (reg_be[b]) regs[reg_addr[5:0]][8*b +: 8] <= reg_wdata[8*b +: 8];
            end
            if (reg_rd) begin
                rd_cnt++;
                last_rd_addr = reg_addr;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_xfer(input logic wr, input logic [13:0] a, input logic [31:0] d,
                            input logic [3:0] be, output logic [31:0] rd,
                            output int waits, output int lat);
        @(negedge cpu_clk);
        bus_addr = a; bus_write = wr; bus_read = !wr; bus_wdata = d; bus_be = be;
        waits = 0; lat = -1; rd = 'x;
        #1;
        while (bus_wait && waits < 1000) begin
            waits++;
            @(negedge cpu_clk);
            #1;
        end
        if (bus_rvalid) begin rd = bus_rdata; lat = 0; end
        @(posedge cpu_clk);
        @(negedge cpu_clk);
        bus_write = 1'b0; bus_read = 1'b0;
        if (!wr && lat < 0) begin
            for (int k = 1; k <= 8; k++) begin
                #1;
                if (bus_rvalid) begin rd = bus_rdata; lat = k; break; end
                @(negedge cpu_clk);
            end
        end
        repeat (3) @(posedge usr_clk);
        #0.1;
    endtask

    task automatic t_reset;
        repeat (20) @(posedge usr_clk);
        @(negedge cpu_clk); #1;
        chk("R9 wait idle", 32'(bus_wait), 32'd0);
        chk("R9 rvalid idle", 32'(bus_rvalid), 32'd0);
        chk("R9 no strobes", 32'(wr_cnt + rd_cnt), 32'd0);
    endtask

    task automatic t_fwd_write;
        logic [31:0] rd; int w, l;
        bus_xfer(1'b1, 14'h0024, 32'h1234_5678, 4'hF, rd, w, l);
        chk("R4 one write strobe", 32'(wr_cnt), 32'd1);
        chk("R4 word address", 32'(last_wr_addr), 32'h009);
        chk("R4 write data", last_wdata, 32'h1234_5678);
        chk("R7 waited at least 3", 32'(w >= 3), 32'd1);
        chk("R1 code 0 forwarded, no read", 32'(rd_cnt), 32'd0);
    endtask

    task automatic t_fwd_read;
        logic [31:0] rd; int w, l;
        bus_xfer(1'b0, 14'h0024, 32'h0, 4'hF, rd, w, l);
        chk("R6 read data", rd, 32'h1234_5678);
        chk("R6 rvalid at release", 32'(l), 32'd0);
        chk("R6 one read strobe", 32'(rd_cnt), 32'd1);
        chk("R6 read word address", 32'(last_rd_addr), 32'h009);
    endtask

    task automatic t_byte_lanes;
        logic [31:0] rd; int w, l;
        bus_xfer(1'b1, 14'h0024, 32'hAABB_CCDD, 4'b0101, rd, w, l);
        chk("R5 lanes carried", 32'(last_be), 32'h5);
        bus_xfer(1'b0, 14'h0024, 32'h0, 4'hF, rd, w, l);
        chk("R5 merged value", rd, 32'h12BB_56DD);
    endtask

    task automatic t_windows;
        logic [31:0] rd; int w, l; int wr0;
        wr0 = wr_cnt;
        bus_xfer(1'b1, 14'h0210, 32'hCAFE_0001, 4'hF, rd, w, l);
        chk("R2 window 0 no wait", 32'(w), 32'd0);
        bus_xfer(1'b1, 14'h0410, 32'hBEEF_0002, 4'hF, rd, w, l);
        bus_xfer(1'b1, 14'h0410, 32'h1100_0000, 4'b1000, rd, w, l);
        chk("R2 no register strobe", 32'(wr_cnt), 32'(wr0));
        bus_xfer(1'b0, 14'h0210, 32'h0, 4'hF, rd, w, l);
        chk("R3 window 0 data", rd, 32'hCAFE_0001);
        chk("R3 window 0 latency", 32'(l), 32'd2);
        chk("R3 window read no wait", 32'(w), 32'd0);
        bus_xfer(1'b0, 14'h0410, 32'h0, 4'hF, rd, w, l);
        chk("R3 window 1 data with lane", rd, 32'h11EF_0002);
        chk("R3 window 1 latency", 32'(l), 32'd2);
    endtask

    task automatic t_other_codes;
        logic [31:0] rd; int w, l; int wr0;
        wr0 = wr_cnt;
        bus_xfer(1'b1, 14'h07FC, 32'h0000_0003, 4'hF, rd, w, l);
        chk("R1 code 3 forwarded", 32'(last_wr_addr), 32'h1FF);
        bus_xfer(1'b1, 14'h3FFC, 32'h0000_001F, 4'hF, rd, w, l);
        chk("R1 code 31 forwarded", 32'(last_wr_addr), 32'hFFF);
        chk("R1 strobe count", 32'(wr_cnt - wr0), 32'd2);
    endtask

    task automatic t_clock_ratio;
        logic [31:0] rd; int w, l;
        usr_half = 1.5;
        bus_xfer(1'b1, 14'h0030, 32'h0BAD_F00D, 4'hF, rd, w, l);
        bus_xfer(1'b0, 14'h0030, 32'h0, 4'hF, rd, w, l);
        chk("R10 fast user clock", rd, 32'h0BAD_F00D);
        usr_half = 9.0;
        bus_xfer(1'b0, 14'h0030, 32'h0, 4'hF, rd, w, l);
        chk("R10 slow user clock", rd, 32'h0BAD_F00D);
        usr_half = 5.0;
    endtask

    task automatic t_back_to_back;
        logic [31:0] rd; int w, l; int wr0;
        wr0 = wr_cnt;
        for (int i = 0; i < 4; i++)
            bus_xfer(1'b1, 14'(14'h0040 + 4*i), 32'hA000_0000 + i, 4'hF, rd, w, l);
        chk("R8 one strobe each", 32'(wr_cnt - wr0), 32'd4);
        chk("R8 no overlap", 32'(both_cnt), 32'd0);
        for (int i = 0; i < 4; i++) begin
            bus_xfer(1'b0, 14'(14'h0040 + 4*i), 32'h0, 4'hF, rd, w, l);
            chk("R8 readback", rd, 32'hA000_0000 + i);
        end
    endtask

    initial begin
        repeat (6) @(posedge usr_clk);
        @(posedge cpu_clk); cpu_rst = 1'b0;
        @(posedge usr_clk); usr_rst = 1'b0;
        t_reset();
        t_fwd_write();
        t_fwd_read();
        t_byte_lanes();
        t_windows();
        t_other_codes();
        t_clock_ratio();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge cpu_clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule